// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frame bytes into memory through a ring of buffer descriptors that software prepares. Each descriptor takes two 32-bit words. The first word holds a status field and a length field. The second word holds the buffer address. Software programs the ring base address and the buffer size. It then writes the kick register to start polling. The engine reads the current descriptor. If the descriptor is marked empty, the engine takes bytes from a byte stream with an end-of-frame marker. It packs the bytes into words, writes them into the buffer, and then writes the descriptor back with the empty bit cleared.

A frame longer than one buffer spills into the following descriptors. The descriptor that closes a frame carries the last bit and the total frame length, CRC bytes included. A descriptor whose wrap bit is set sends the engine back to index 0. If the engine meets a descriptor that is not empty, it stops polling and waits until software writes the kick register again. Memory is reached through one request/acknowledge port. A request stays up until it is acknowledged, and read data is valid with the acknowledge.

Top module: `rxd_ring_engine`

## Requirements
- R1: While reset is held, and until the first kick, there is no memory request, `rx_ready` and `frame_done` are low, and `poll_active` is low.
- R2: A register write with `csr_sel`=2 and bit 24 of the data set makes `poll_active` high from the next cycle. The same write with bit 24 clear has no effect. `csr_sel`=0 loads the ring base and restarts at index 0. `csr_sel`=1 loads the buffer size in bytes.
- R3: Descriptor i sits at ring base + 8·i. Its word 0 has status in bits 31:16 and length in bits 15:0. Its word 1 is the buffer address. Within the status field, bit 15 is empty, bit 13 is wrap, bit 11 is last and bit 0 is error. Every memory access is word aligned.
- R4: When a fetched descriptor lacks the empty bit, `poll_active` falls and no stream byte is accepted until the next kick.
- R5: Frame bytes are stored in arrival order from the start of the buffer, with the first byte of each word in bits 7:0.
- R6: When a buffer fills before the frame ends, its descriptor is written back with empty and last clear and a length equal to the buffer size. The frame then continues in the next descriptor.
- R7: The descriptor holding the final byte is written back with empty clear, last set and a length equal to the whole frame's byte count, the 4 CRC bytes included.
- R8: After a descriptor with the wrap bit set, the next descriptor used is index 0. The wrap bit is kept in the written-back status.
- R9: The error bit is set on a frame's last descriptor exactly when the frame exceeds 1522 bytes. A 1522-byte frame has it clear.
- R10: `frame_done` pulses high for one cycle, in the cycle after the acknowledge of a last descriptor's write-back.
- R11: A partial final word is written with byte strobes only on the lanes that hold frame bytes, so buffer bytes past the frame keep their contents.
- R12: A memory request holds its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 ring base, 1 buffer size, 2 kick |
| csr_wdata | input | 32 | Register write data |
| poll_active | output | 1 | Descriptor polling is enabled |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte lane strobes for writes |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Byte is the final byte of its frame |
| rx_ready | output | 1 | Engine accepts a stream byte this cycle |
| frame_done | output | 1 | One-cycle pulse per completed frame |

## Verification
A kick written at one clock edge shows on `poll_active` in the cycle that follows. The bench memory raises `mem_ack` one cycle after it sees a request. A descriptor write-back is therefore compared in the cycle where the request is up and the acknowledge is still low. The scoreboard expects `frame_done` two cycles after a last write-back is first seen, and checks that through a two-stage pipeline advanced once per cycle. Buffer contents and untouched bytes are read from the bench memory only after the expected write-backs have all drained, plus a few idle cycles.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned LANES     = DATA_W / 8;
  localparam int unsigned LEN_W     = 16;
  localparam int unsigned STAT_LSB  = 16;
  localparam int unsigned FLD_EMPTY = 15;
  localparam int unsigned FLD_WRAP  = 13;
  localparam int unsigned FLD_LAST  = 11;
  localparam int unsigned FLD_ERR   = 0;
  localparam int unsigned KICK_BIT  = 24;

  typedef enum logic [1:0] {
    CSR_RING_BASE = 2'd0,
    CSR_BUF_SIZE  = 2'd1,
    CSR_KICK      = 2'd2
  } csr_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_PTR, ST_FILL, ST_DATA, ST_STAT
  } eng_state_e;
endpackage

// File: rtl/rxd_ring_index.sv
module rxd_ring_index #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] desc_addr
);
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             idx_en;

  always_comb begin
    idx_en = clear | advance;
    if (clear || wrap) idx_n = '0;
    else               idx_n = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_n;
  end

  assign desc_addr = base + AW'({idx_q, 3'b000});
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int unsigned LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [7:0]         din,
  input  logic               flush,
  output logic [LANES*8-1:0] word,
  output logic [LANES-1:0]   strb,
  output logic               full_next
);
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANE_W-1:0] lane_q, lane_n;
  logic [LANES-1:0]  strb_q, strb_n;

  always_comb begin
    lane_n = lane_q;
    strb_n = strb_q;
    if (flush) begin
      lane_n = '0;
      strb_n = '0;
    end else if (take) begin
      lane_n = lane_q + 1'b1;
      strb_n = strb_q | (LANES'(1) << lane_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      strb_q <= '0;
    end else begin
      lane_q <= lane_n;
      strb_q <= strb_n;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic       hit;
    logic [7:0] b_q;
    assign hit = take && (lane_q == LANE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   b_q <= '0;
      else if (hit) b_q <= din;
    end
    assign word[g*8 +: 8] = b_q;
  end

  assign strb      = strb_q;
  assign full_next = (lane_q == LANE_W'(LANES - 1));
endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine
  import rxd_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned IDX_W     = 12,
  parameter int unsigned MAX_FRAME = 1522
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [31:0]       csr_wdata,
  output logic              poll_active,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_wstrb,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              rx_ready,
  output logic              frame_done
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  eng_state_e       st_q, st_n;
  logic             active_q, kick_set, act_clr;
  logic [AW-1:0]    base_q, ptr_q, ptr_n, desc_addr;
  logic [LEN_W-1:0] bsize_q, dcnt_q, dcnt_n, fcnt_q, fcnt_n, len_wb;
  logic [15:0]      stat_q, stat_wb;
  logic             base_en, bsize_en, stat_en, ptr_en, dcnt_en, fcnt_en;
  logic             last_q, last_n, last_en, done_q, done_n;
  logic             take, flush, advance, pk_full;
  logic [DATA_W-1:0] pk_word;
  logic [LANES-1:0]  pk_strb;

  assign base_en  = csr_we && (csr_sel == CSR_RING_BASE);
  assign bsize_en = csr_we && (csr_sel == CSR_BUF_SIZE);
  assign kick_set = csr_we && (csr_sel == CSR_KICK) && csr_wdata[KICK_BIT];

  rxd_ring_index #(.AW(AW), .IDX_W(IDX_W)) ring_i (
    .clk(clk), .rst_n(rst_i_n), .clear(base_en), .advance(advance),
    .wrap(stat_q[FLD_WRAP]), .base(base_q), .desc_addr(desc_addr)
  );

  rxd_packer #(.LANES(LANES)) pack_i (
    .clk(clk), .rst_n(rst_i_n), .take(take), .din(rx_data), .flush(flush),
    .word(pk_word), .strb(pk_strb), .full_next(pk_full)
  );

  always_comb begin
    stat_wb            = stat_q;
    stat_wb[FLD_EMPTY] = 1'b0;
    stat_wb[FLD_LAST]  = last_q;
    stat_wb[FLD_ERR]   = last_q && (fcnt_q > LEN_W'(MAX_FRAME));
    len_wb             = last_q ? fcnt_q : dcnt_q;
  end

  always_comb begin
    st_n = st_q;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = desc_addr;
    mem_wdata = '0; mem_wstrb = '0; rx_ready = 1'b0;
    take = 1'b0; flush = 1'b0; act_clr = 1'b0; advance = 1'b0;
    stat_en = 1'b0; ptr_en = 1'b0; ptr_n = ptr_q;
    dcnt_en = 1'b0; dcnt_n = dcnt_q; fcnt_en = 1'b0; fcnt_n = fcnt_q;
    last_en = 1'b0; last_n = last_q; done_n = 1'b0;
    case (st_q)
      ST_IDLE: if (active_q) st_n = ST_HDR;
      ST_HDR: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          if (mem_rdata[STAT_LSB + FLD_EMPTY]) begin
            stat_en = 1'b1;
            st_n    = ST_PTR;
          end else begin
            act_clr = 1'b1;
            st_n    = ST_IDLE;
          end
        end
      end
      ST_PTR: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(4);
        if (mem_ack) begin
          ptr_en  = 1'b1;
          ptr_n   = mem_rdata[AW-1:0];
          dcnt_en = 1'b1;
          dcnt_n  = '0;
          st_n    = ST_FILL;
        end
      end
      ST_FILL: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          take    = 1'b1;
          dcnt_en = 1'b1;
          dcnt_n  = dcnt_q + 1'b1;
          fcnt_en = 1'b1;
          fcnt_n  = (fcnt_q == '1) ? fcnt_q : fcnt_q + 1'b1;
          last_en = 1'b1;
          last_n  = rx_last;
          if (rx_last || pk_full || (dcnt_n == bsize_q)) st_n = ST_DATA;
        end
      end
      ST_DATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q;
        mem_wdata = pk_word;
        mem_wstrb = pk_strb;
        if (mem_ack) begin
          flush  = 1'b1;
          ptr_en = 1'b1;
          ptr_n  = ptr_q + AW'(4);
          st_n   = (last_q || (dcnt_q == bsize_q)) ? ST_STAT : ST_FILL;
        end
      end
      ST_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {stat_wb, len_wb};
        mem_wstrb = '1;
        if (mem_ack) begin
          advance = 1'b1;
          done_n  = last_q;
          last_en = 1'b1;
          last_n  = 1'b0;
          if (last_q) begin
            fcnt_en = 1'b1;
            fcnt_n  = '0;
          end
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q     <= ST_IDLE;
      active_q <= 1'b0;
      base_q   <= '0;
      bsize_q  <= '0;
      stat_q   <= '0;
      ptr_q    <= '0;
      dcnt_q   <= '0;
      fcnt_q   <= '0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      if (kick_set)     active_q <= 1'b1;
      else if (act_clr) active_q <= 1'b0;
      if (base_en)  base_q  <= csr_wdata[AW-1:0];
      if (bsize_en) bsize_q <= csr_wdata[LEN_W-1:0];
      if (stat_en)  stat_q  <= mem_rdata[STAT_LSB +: 16];
      if (ptr_en)   ptr_q   <= ptr_n;
      if (dcnt_en)  dcnt_q  <= dcnt_n;
      if (fcnt_en)  fcnt_q  <= fcnt_n;
      if (last_en)  last_q  <= last_n;
    end
  end

  assign poll_active = active_q;
  assign frame_done  = done_q;
endmodule

// File: rtl/rxd_ring_engine_chk.sv
module rxd_ring_engine_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          poll_active,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_wstrb,
  input logic          mem_ack,
  input logic          rx_ready,
  input logic          frame_done
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(mem_req && mem_we && mem_ack));

  // R4
  fill_needs_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> poll_active);

  // R3
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R11
  write_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wstrb != 4'b0000);
endmodule

bind rxd_ring_engine rxd_ring_engine_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .poll_active(poll_active), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb),
  .mem_ack(mem_ack), .rx_ready(rx_ready), .frame_done(frame_done)
);

// File: tb/rxd_ring_engine_tb_top.sv
`timescale 1ns/1ps
module rxd_ring_engine_tb_top;
  localparam int RING = 4;
  localparam int BUF0 = 32'h1000;
  localparam int BSTEP = 32'h800;

  logic        clk, rst_n;
  logic        csr_we;
  logic [1:0]  csr_sel;
  logic [31:0] csr_wdata;
  logic        poll_active, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;
  logic        rx_valid, rx_last, rx_ready, frame_done;
  logic [7:0]  rx_data;

  logic [31:0] mem [4096];

  typedef struct {
    logic [31:0] addr;
    logic [31:0] word;
    bit          last;
    string       tag;
  } wb_t;
  wb_t sb[$];

  int checks = 0, errors = 0;
  int m_idx = 0, bsize_tb = 0;
  bit finished = 0;

  rxd_ring_engine dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .poll_active(poll_active), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_ready(rx_ready), .frame_done(frame_done)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic check(input string tag, input bit ok,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder: acknowledge one cycle after a request
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_wstrb[k]) mem[mem_addr[13:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
        end else begin
          mem_rdata <= mem[mem_addr[13:2]];
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  // monitor: descriptor write-backs and completion pulse
  initial begin
    bit [1:0] dpipe;
    dpipe = 2'b00;
    forever begin
      bit  nl;
      wb_t e;
      @(negedge clk);
      nl = 1'b0;
      if (rst_n) begin
        if (mem_req && mem_we && !mem_ack && mem_addr < 32) begin
          if (sb.size() == 0) begin
            check("R6 unexpected write-back", 1'b0, {32'h0, mem_addr}, 64'h0);
          end else begin
            e = sb.pop_front();
            check(e.tag, (mem_addr == e.addr) && (mem_wdata == e.word),
                  {mem_addr, mem_wdata}, {e.addr, e.word});
            nl = e.last;
          end
        end
        if (frame_done || dpipe[1])
          check("R10 frame_done timing", frame_done == dpipe[1],
                {63'h0, frame_done}, {63'h0, dpipe[1]});
        dpipe = {dpipe[0], nl};
      end
    end
  end

  function automatic logic [7:0] pat(input int seed, input int j);
    return 8'((seed * 37 + j * 7) & 255);
  endfunction

  function automatic logic [7:0] rd_byte(input int a);
    return mem[a >> 2][(a % 4) * 8 +: 8];
  endfunction

  task automatic set_desc(input int i, input bit wrap);
    mem[i*2]   <= {(wrap ? 16'hA000 : 16'h8000), 16'h0000};
    mem[i*2+1] <= BUF0 + i * BSTEP;
  endtask

  task automatic csr_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, input bit l);
    rx_valid = 1'b1; rx_data = b; rx_last = l;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  // driver: pushes expected write-backs, drives the frame, checks buffers
  task automatic send_frame(input int len, input int seed);
    int rem, off, segs, errs;
    int sidx[8], soff[8], sn[8];
    logic [15:0] st;
    logic [7:0]  got, want;
    rem = len; off = 0; segs = 0; errs = 0; got = 0; want = 0;
    while (rem > 0) begin
      int n; bit last, wrap; wb_t e;
      n    = (rem < bsize_tb) ? rem : bsize_tb;
      last = (rem <= bsize_tb);
      wrap = (m_idx == RING - 1);
      st   = (wrap ? 16'h2000 : 16'h0) | (last ? 16'h0800 : 16'h0) |
             ((last && len > 1522) ? 16'h0001 : 16'h0);
      e.addr = m_idx * 8;
      e.word = {st, (last ? 16'(len) : 16'(bsize_tb))};
      e.last = last;
      e.tag  = wrap ? "R8 wrap write-back" :
               (last && len > 1522) ? "R9 error write-back" :
               last ? "R7 last write-back" : "R6 full-buffer write-back";
      sb.push_back(e);
      sidx[segs] = m_idx; soff[segs] = off; sn[segs] = n;
      segs++;
      m_idx = wrap ? 0 : m_idx + 1;
      rem -= n; off += n;
    end
    for (int j = 0; j < len; j++) put_byte(pat(seed, j), j == len - 1);
    rx_valid = 1'b0; rx_last = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    for (int s = 0; s < segs; s++)
      for (int b = 0; b < sn[s]; b++) begin
        logic [7:0] g, w;
        g = rd_byte(BUF0 + sidx[s] * BSTEP + b);
        w = pat(seed, soff[s] + b);
        if (g !== w) begin
          if (errs == 0) begin got = g; want = w; end
          errs++;
        end
      end
    check("R5 buffer contents", errs == 0, {56'h0, got}, {56'h0, want});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csr_we = 1'b0; csr_sel = 2'd0; csr_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset mem_req", mem_req == 1'b0, {63'h0, mem_req}, 64'h0);
    check("R1 reset rx_ready", rx_ready == 1'b0, {63'h0, rx_ready}, 64'h0);
    check("R1 reset frame_done", frame_done == 1'b0, {63'h0, frame_done}, 64'h0);
    rst_n = 1'b1;
    for (int w = BUF0 / 4; w < 32'h3000 / 4; w++) mem[w] <= 32'hA5A5A5A5;
    for (int i = 0; i < RING; i++) set_desc(i, i == RING - 1);
    repeat (4) @(negedge clk);
    csr_write(2'd0, 32'h0);
    csr_write(2'd1, 32'd64); bsize_tb = 64;
    check("R1 idle before kick", poll_active == 1'b0 && mem_req == 1'b0,
          {62'h0, poll_active, mem_req}, 64'h0);
    csr_write(2'd2, 32'h0100_0000);
    check("R2 kick starts polling", poll_active == 1'b1, {63'h0, poll_active}, 64'h1);

    send_frame(30, 1);
    check("R11 byte 30 untouched", rd_byte(BUF0 + 30) == 8'hA5,
          {56'h0, rd_byte(BUF0 + 30)}, 64'hA5);
    check("R11 byte 31 untouched", rd_byte(BUF0 + 31) == 8'hA5,
          {56'h0, rd_byte(BUF0 + 31)}, 64'hA5);
    send_frame(100, 2);
    send_frame(20, 3);

    repeat (20) @(negedge clk);
    check("R4 stop on full descriptor", poll_active == 1'b0, {63'h0, poll_active}, 64'h0);
    check("R4 no byte accepted", rx_ready == 1'b0, {63'h0, rx_ready}, 64'h0);
    csr_write(2'd2, 32'h0000_0001);
    repeat (10) @(negedge clk);
    check("R2 kick without bit 24 ignored", poll_active == 1'b0 && rx_ready == 1'b0,
          {62'h0, poll_active, rx_ready}, 64'h0);

    set_desc(0, 1'b0);
    @(negedge clk);
    csr_write(2'd2, 32'h0100_0000);
    send_frame(10, 4);
    repeat (20) @(negedge clk);
    check("R4 stop after ring reuse", poll_active == 1'b0, {63'h0, poll_active}, 64'h0);

    for (int i = 1; i < RING; i++) set_desc(i, i == RING - 1);
    @(negedge clk);
    csr_write(2'd1, 32'd2048); bsize_tb = 2048;
    csr_write(2'd2, 32'h0100_0000);
    send_frame(1530, 5);
    send_frame(1522, 6);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule